// File: doc/BRIEF.md
# Programmable Chip Select and Cycle Acknowledge Unit

This unit decodes every bus cycle against a small set of programmable address windows. It drives the active-low select line of the window that matches, and it can end the cycle with an acknowledge that it generates itself. Each window has a base, a mask, an enable, a port-width bit, an internal-acknowledge enable and a wait-state count. The internal acknowledge arrives after the programmed number of clocks. It uses one of two acknowledge lines to tell the bus master how wide the port is.

Devices outside the unit may also acknowledge a cycle. The unit watches their acknowledge lines the whole time it is counting. If one of them responds first, the unit stops counting and stays silent for the rest of that cycle. A strap input sets the width that every window takes at reset. Configuration is written through a simple write-enable port, one window at a time. The width bit has a separate enable, so a window can keep the width that came from the strap.

Top module: `cs_ack_unit`

## Requirements
- R1: After reset every window is disabled: all `cs_n` bits and both `ack_n` bits are high, and a bus cycle to any address asserts neither.
- R2: Each window's width bit is loaded from the value `width_strap` holds on the last clock edge before `rst_n` rises: low means 8-bit, high means 16-bit.
- R3: A window matches when `(addr & mask) == (base & mask)` and it is enabled. When several windows match, the lowest index wins, and at most one `cs_n` bit is low at any time.
- R4: `cs_n[i]` goes low on the first clock edge that samples `as_n` low. All `cs_n` and `ack_n` bits return high on the first edge that samples `as_n` high.
- R5: With internal acknowledge enabled and a wait count W, `ack_n` goes low W clocks after `cs_n` goes low. W = 0 asserts `ack_n` on the same edge as `cs_n`.
- R6: A wait count of 14 or 15 is stored as 13.
- R7: The internal acknowledge drives `ack_n = 2'b10` (line 0 low) for an 8-bit window and `ack_n = 2'b01` (line 1 low) for a 16-bit window. It never drives both lines low.
- R8: The unit samples `ext_ack_n` on each edge after `cs_n` goes low. If either bit is low before the internal acknowledge has fired, the internal acknowledge is not asserted for the rest of the cycle.
- R9: A window with internal acknowledge disabled asserts only its `cs_n` and leaves `ack_n` high.
- R10: An address that matches no enabled window asserts no `cs_n` and no `ack_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| width_strap | input | 1 | Default port width at reset (0 = 8-bit, 1 = 16-bit) |
| cfg_we | input | 1 | Write base, mask, enable, ack enable and wait count of window `cfg_idx` |
| cfg_width_we | input | 1 | Write the width bit of window `cfg_idx` |
| cfg_idx | input | IDX_W | Window being written |
| cfg_base | input | ADDR_W | Base address |
| cfg_mask | input | ADDR_W | Address compare mask (1 = bit compared) |
| cfg_en | input | 1 | Window enable |
| cfg_iack | input | 1 | Internal acknowledge enable |
| cfg_ws | input | 4 | Wait-state count, clamped to 13 |
| cfg_w16 | input | 1 | Width bit (1 = 16-bit) |
| as_n | input | 1 | Active-low address strobe |
| addr | input | ADDR_W | Bus address |
| ext_ack_n | input | 2 | Acknowledge lines driven by external devices |
| cs_n | output | NUM_REGIONS | Active-low chip selects |
| ack_n | output | 2 | Internally generated acknowledge |

## Verification
The bench builds the unit with its defaults: four windows and a 24-bit address. Four windows are enough to set up two overlapping windows and still have one window for the clamped wait count and one for a window without acknowledge, all in the same run. The bench resets the unit twice with different strap levels and toggles the strap during reset, which shows that only the last sampled level counts. It counts clocks from the select edge to the acknowledge edge for wait counts of 0, 3, 5 and a written 15. An external acknowledge in the middle of a 13-clock wait shows the early ending.

// File: rtl/cs_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, the per-window configuration record and
// small helpers for the chip-select unit.
package cs_pkg;
    parameter int CS_ADDR_W = 24;
    localparam int WS_W   = 4;
    localparam int MAX_WS = 13;

    typedef struct packed {
        logic [CS_ADDR_W-1:0] base;
        logic [CS_ADDR_W-1:0] mask;
        logic                 en;
        logic                 iack;
        logic                 w16;
        logic [WS_W-1:0]      ws;
    } region_cfg_t;

    // Acknowledge code: line 0 low for 8-bit, line 1 low for 16-bit.
    function automatic logic [1:0] ack_code(input logic w16);
        return w16 ? 2'b01 : 2'b10;
    endfunction

    // Limit a requested wait count to the supported maximum.
    function automatic logic [WS_W-1:0] clamp_ws(input logic [WS_W-1:0] ws);
        return (ws > WS_W'(MAX_WS)) ? WS_W'(MAX_WS) : ws;
    endfunction
endpackage

// File: rtl/cs_regfile.sv
`timescale 1ns/1ps
// cs_regfile: holds the configuration of every window.
// Assumes: a synchronous active-low reset. The width bit takes the strap
// level on each reset clock, so the last one before release is kept.
module cs_regfile
    import cs_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 width_strap,
    input  logic                 cfg_we,
    input  logic                 cfg_width_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [CS_ADDR_W-1:0] cfg_base,
    input  logic [CS_ADDR_W-1:0] cfg_mask,
    input  logic                 cfg_en,
    input  logic                 cfg_iack,
    input  logic [WS_W-1:0]      cfg_ws,
    input  logic                 cfg_w16,
    output region_cfg_t          cfg [NUM_REGIONS]
);
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
        // Per-window storage: reset defaults, then field writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[g].base <= '0;
                cfg[g].mask <= '0;
                cfg[g].en   <= 1'b0;
                cfg[g].iack <= 1'b0;
                cfg[g].ws   <= '0;
                cfg[g].w16  <= width_strap;
            end else begin
                if (cfg_we && cfg_idx == IDX_W'(g)) begin
                    cfg[g].base <= cfg_base;
                    cfg[g].mask <= cfg_mask;
                    cfg[g].en   <= cfg_en;
                    cfg[g].iack <= cfg_iack;
                    cfg[g].ws   <= clamp_ws(cfg_ws);
                end
                if (cfg_width_we && cfg_idx == IDX_W'(g))
                    cfg[g].w16 <= cfg_w16;
            end
        end

        assert_ws_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cfg[g].ws <= WS_W'(MAX_WS));
    end
endmodule

// File: rtl/cs_decode.sv
`timescale 1ns/1ps
// cs_decode: combinational address match of every window.
// Assumes: the lowest-indexed enabled match wins.
module cs_decode
    import cs_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CS_ADDR_W-1:0] addr,
    input  region_cfg_t          cfg [NUM_REGIONS],
    output logic                 hit,
    output logic [IDX_W-1:0]     hit_idx
);
    // Priority match: scan downward so the lowest index is written last.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (cfg[i].en && ((addr & cfg[i].mask) == (cfg[i].base & cfg[i].mask))) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assert_hit_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> cfg[hit_idx].en);
endmodule

// File: rtl/cs_cycle.sv
`timescale 1ns/1ps
// cs_cycle: per-bus-cycle sequencer. It latches the winning window when the
// strobe first falls, drives its select, counts wait states and issues the
// internal acknowledge unless an external one arrives first.
// Assumes: as_n is synchronous to clk; a cycle lasts until as_n rises.
module cs_cycle
    import cs_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   as_n,
    input  logic [1:0]             ext_ack_n,
    input  logic                   hit,
    input  logic [IDX_W-1:0]       hit_idx,
    input  region_cfg_t            cfg [NUM_REGIONS],
    output logic [NUM_REGIONS-1:0] cs_n,
    output logic [1:0]             ack_n
);
    logic             active;
    logic             hit_q;
    logic             ext_done;
    logic [IDX_W-1:0] sel;
    logic [WS_W-1:0]  cnt;
    logic [WS_W-1:0]  cnt_nxt;

    assign cnt_nxt = cnt + WS_W'(1);

    // Cycle sequencer: start on strobe, count, acknowledge, clear on negate.
    always_ff @(posedge clk) begin
        if (!rst_n || as_n) begin
            active   <= 1'b0;
            hit_q    <= 1'b0;
            ext_done <= 1'b0;
            sel      <= '0;
            cnt      <= '0;
            cs_n     <= '1;
            ack_n    <= 2'b11;
        end else if (!active) begin
            active <= 1'b1;
            hit_q  <= hit;
            sel    <= hit_idx;
            cnt    <= '0;
            if (hit) begin
                cs_n <= ~(NUM_REGIONS'(1) << hit_idx);
                if (cfg[hit_idx].iack && cfg[hit_idx].ws == '0)
                    ack_n <= ack_code(cfg[hit_idx].w16);
            end
        end else if (hit_q && ack_n == 2'b11 && !ext_done) begin
            if (ext_ack_n != 2'b11) begin
                ext_done <= 1'b1;
            end else if (cnt != WS_W'(MAX_WS)) begin
                cnt <= cnt_nxt;
                if (cfg[sel].iack && cnt_nxt == cfg[sel].ws)
                    ack_n <= ack_code(cfg[sel].w16);
            end
        end
    end

    assert_single_select_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));
    assert_clear_on_negate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |=> (cs_n == '1 && ack_n == 2'b11));
    assert_ack_has_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_n != 2'b11) |-> (cs_n != '1));
    assert_one_ack_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n != 2'b00);
    assert_silent_after_ext_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ext_done |-> ack_n == 2'b11);
endmodule

// File: rtl/cs_ack_unit.sv
`timescale 1ns/1ps
// cs_ack_unit: top of the programmable chip-select and acknowledge unit.
// Assumes: synchronous active-low reset; address width set by the package.
module cs_ack_unit
    import cs_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    localparam int IDX_W  = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int ADDR_W = CS_ADDR_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   width_strap,
    input  logic                   cfg_we,
    input  logic                   cfg_width_we,
    input  logic [IDX_W-1:0]       cfg_idx,
    input  logic [ADDR_W-1:0]      cfg_base,
    input  logic [ADDR_W-1:0]      cfg_mask,
    input  logic                   cfg_en,
    input  logic                   cfg_iack,
    input  logic [3:0]             cfg_ws,
    input  logic                   cfg_w16,
    input  logic                   as_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [1:0]             ext_ack_n,
    output logic [NUM_REGIONS-1:0] cs_n,
    output logic [1:0]             ack_n
);
    region_cfg_t      cfg [NUM_REGIONS];
    logic             hit;
    logic [IDX_W-1:0] hit_idx;

    cs_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regs (
        .clk(clk), .rst_n(rst_n), .width_strap(width_strap),
        .cfg_we(cfg_we), .cfg_width_we(cfg_width_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
        .cfg_iack(cfg_iack), .cfg_ws(cfg_ws), .cfg_w16(cfg_w16), .cfg(cfg)
    );

    cs_decode #(.NUM_REGIONS(NUM_REGIONS)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cfg(cfg),
        .hit(hit), .hit_idx(hit_idx)
    );

    cs_cycle #(.NUM_REGIONS(NUM_REGIONS)) u_cyc (
        .clk(clk), .rst_n(rst_n), .as_n(as_n), .ext_ack_n(ext_ack_n),
        .hit(hit), .hit_idx(hit_idx), .cfg(cfg), .cs_n(cs_n), .ack_n(ack_n)
    );
endmodule

// File: tb/cs_ack_unit_tb.sv
`timescale 1ns/1ps
// Directed bench for cs_ack_unit: one task per scenario.
module cs_ack_unit_tb;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        width_strap = 1'b0;
    logic        cfg_we = 1'b0, cfg_width_we = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [23:0] cfg_base = '0, cfg_mask = '0;
    logic        cfg_en = 1'b0, cfg_iack = 1'b0, cfg_w16 = 1'b0;
    logic [3:0]  cfg_ws = '0;
    logic        as_n = 1'b1;
    logic [23:0] addr = '0;
    logic [1:0]  ext_ack_n = 2'b11;
    logic [N-1:0] cs_n;
    logic [1:0]  ack_n;

    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cs_ack_unit u_dut (
        .clk(clk), .rst_n(rst_n), .width_strap(width_strap),
        .cfg_we(cfg_we), .cfg_width_we(cfg_width_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_en(cfg_en),
        .cfg_iack(cfg_iack), .cfg_ws(cfg_ws), .cfg_w16(cfg_w16),
        .as_n(as_n), .addr(addr), .ext_ack_n(ext_ack_n),
        .cs_n(cs_n), .ack_n(ack_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reset; the strap holds the opposite level until the last reset edge.
    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n = 1'b0;
        width_strap = ~strap;
        repeat (2) @(negedge clk);
        width_strap = strap;
        @(negedge clk);
        rst_n = 1'b1;
        width_strap = ~strap;
    endtask

    task automatic write_region(input int idx, input logic [23:0] base, input logic [23:0] mask,
                                input logic en, input logic iack, input logic [3:0] ws);
        @(negedge clk);
        cfg_idx = 2'(idx); cfg_base = base; cfg_mask = mask;
        cfg_en = en; cfg_iack = iack; cfg_ws = ws; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic write_width(input int idx, input logic w16);
        @(negedge clk);
        cfg_idx = 2'(idx); cfg_w16 = w16; cfg_width_we = 1'b1;
        @(negedge clk);
        cfg_width_we = 1'b0;
    endtask

    // One bus cycle: reports the select seen on edge 1, the first edge with
    // ack and its code. ext_at = edge at which external ack is first sampled.
    task automatic bus_cycle(input logic [23:0] a, input int hold, input int ext_at,
                             output int cs_idx, output int ack_at, output int ack_val);
        cs_idx = -1; ack_at = -1; ack_val = 3;
        @(negedge clk);
        addr = a; as_n = 1'b0;
        for (int k = 1; k <= hold; k++) begin
            if (k == ext_at) ext_ack_n = 2'b10;
            @(posedge clk); #1;
            if (k == 1) begin
                for (int i = 0; i < N; i++) if (!cs_n[i]) cs_idx = i;
            end
            if (ack_n != 2'b11 && ack_at < 0) begin
                ack_at = k; ack_val = int'(ack_n);
            end
            @(negedge clk);
        end
        as_n = 1'b1; ext_ack_n = 2'b11;
        @(posedge clk); #1;
        check(cs_n == '1 && ack_n == 2'b11, "R4 clear on negate", int'({cs_n, ack_n}), 63);
    endtask

    task automatic t_reset_state();
        int c, at, v;
        do_reset(1'b0);
        #1;
        check(cs_n == '1, "R1 cs after reset", int'(cs_n), 15);
        check(ack_n == 2'b11, "R1 ack after reset", int'(ack_n), 3);
        bus_cycle(24'h123456, 3, -1, c, at, v);
        check(c == -1, "R1 no select when disabled", c, -1);
        check(at == -1, "R1 no ack when disabled", at, -1);
    endtask

    task automatic t_strap_low_zero_wait();
        int c, at, v;
        write_region(0, 24'h100000, 24'hF00000, 1, 1, 0);
        bus_cycle(24'h123456, 3, -1, c, at, v);
        check(c == 0, "R4 select on first strobe edge", c, 0);
        check(at == 1, "R5 zero wait ack with select", at, 1);
        check(v == 2, "R2 strap low gives 8-bit code", v, 2);
    endtask

    task automatic t_strap_high_three_wait();
        int c, at, v;
        do_reset(1'b1);
        write_region(0, 24'h100000, 24'hF00000, 1, 1, 3);
        bus_cycle(24'h1ABCDE, 6, -1, c, at, v);
        check(c == 0, "R3 masked match", c, 0);
        check(at == 4, "R5 three wait states", at, 4);
        check(v == 1, "R2 strap high gives 16-bit code", v, 1);
    endtask

    task automatic t_priority_and_width();
        int c, at, v;
        write_region(1, 24'h100000, 24'hFF0000, 1, 1, 1);
        bus_cycle(24'h100010, 4, -1, c, at, v);
        check(c == 0, "R3 lowest index wins", c, 0);
        write_region(2, 24'h200000, 24'hF00000, 1, 1, 5);
        write_width(2, 1'b0);
        bus_cycle(24'h2FFFFF, 8, -1, c, at, v);
        check(c == 2, "R3 select window 2", c, 2);
        check(at == 6, "R5 five wait states", at, 6);
        check(v == 2, "R7 8-bit window uses line 0", v, 2);
        bus_cycle(24'h900000, 3, -1, c, at, v);
        check(c == -1 && at == -1, "R10 no match", c, -1);
    endtask

    task automatic t_clamp();
        int c, at, v;
        write_region(3, 24'h300000, 24'hF00000, 1, 1, 15);
        bus_cycle(24'h300000, 16, -1, c, at, v);
        check(c == 3, "R6 select window 3", c, 3);
        check(at == 14, "R6 wait 15 clamped to 13", at, 14);
        check(v == 1, "R7 16-bit window uses line 1", v, 1);
    endtask

    task automatic t_external_ack();
        int c, at, v;
        write_region(3, 24'h300000, 24'hF00000, 1, 1, 13);
        bus_cycle(24'h312345, 16, 4, c, at, v);
        check(c == 3, "R8 select held", c, 3);
        check(at == -1, "R8 external ack suppresses internal", at, -1);
    endtask

    task automatic t_no_internal_ack();
        int c, at, v;
        write_region(1, 24'h400000, 24'hF00000, 1, 0, 0);
        bus_cycle(24'h400000, 5, -1, c, at, v);
        check(c == 1, "R9 select only", c, 1);
        check(at == -1, "R9 no ack", at, -1);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hang expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_strap_low_zero_wait();
        t_strap_high_three_wait();
        t_priority_and_width();
        t_clamp();
        t_external_ack();
        t_no_internal_ack();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule